// File: doc/BRIEF.md
# Permuted Gray-Code Mesh Address Mapper

This block holds the mapping state that makes a hypercube of order `ORDER` act as a two-dimensional processor mesh. The mesh shape can be changed while the system runs. The state has two parts. The first is the split of address bits between the two mesh axes: 2^x nodes along X and 2^y along Y, with x + y = `ORDER`. The second is a permutation that says which physical address bit each Gray-code bit lands on.

A query port takes a mesh coordinate (i, j) and returns three results without waiting for a clock:
- the physical node address of (i, j);
- the address of the node that (i, j) trades data with during a reshape;
- whether (i, j) gives away the high half or the low half of its data.

A one-cycle reshape request halves the X extent of the mesh and doubles its Y extent. It updates the mapping on the next clock edge, so the mesh keeps single-bit adjacency under the new shape. Software or a sequencer can issue the request repeatedly until X has no address bits left. After that point, further requests are refused.

Top module: `pgc_mesh_mapper`

## Requirements
- R1: After reset the X exponent equals `X_EXP0`. The address of (i, j) is the Gray code of i placed in the upper `ORDER-X_EXP0` bits... more precisely, the Gray code of i occupies the bits above the lowest y = `ORDER-X_EXP0` bits, and the Gray code of j occupies the lowest y bits. The reshape-done and reshape-refused outputs are low.
- R2: In general, the address bit selected by permutation entry k receives bit k of gray(i), for k < x. The bit selected by entry x+k receives bit k of gray(j), for k < y. Here gray(n) = n XOR (n >> 1), and every other address bit is zero.
- R3: Bits of `q_i` at positions x and above, and bits of `q_j` at positions y and above, have no effect on any query output.
- R4: Mesh neighbours (i, j)/(i+1 mod 2^x, j) and (i, j)/(i, j+1 mod 2^y) map to addresses that differ in exactly one bit whenever that axis has more than one node.
- R5: A request accepted with x > 0 takes effect at the next clock edge. The new state is x' = x - 1. The first x-1 permutation entries shift down by one, the old entry 0 moves to position x-1, and the Y entries are unchanged. `reconf_done` is high for exactly the one cycle after that edge.
- R6: After an accepted reshape, new address (i, j) equals the old address of (2i, j/2) when (i + j + j/2) is even. When that sum is odd it equals the old address of (2i+1, j/2).
- R7: A request made while x = 0 raises `reconf_err` for one cycle and leaves the exponent and every query result unchanged.
- R8: The partner of (i, j) is (i, j XOR 1) when y > 0, and (i, j) itself when y = 0. `peer_addr` is that partner's address, the relation is mutual, and with y > 0 the two addresses differ in exactly one bit.
- R9: `send_high` is 1 exactly when (i + j + j/2) is odd. With y > 0, the two nodes of a pair always have opposite values.
- R10: With no request, the exponent and all query results hold their values from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reconf_req | input | 1 | Halve-X/double-Y reshape request, sampled at the clock edge |
| q_i | input | ORDER | Query X coordinate (only low x bits used) |
| q_j | input | ORDER | Query Y coordinate (only low y bits used) |
| node_addr | output | ORDER | Physical address of (q_i, q_j) |
| peer_addr | output | ORDER | Physical address of the swap partner |
| send_high | output | 1 | 1: this node gives its high half; 0: its low half |
| x_exp | output | $clog2(ORDER+1) | Current X exponent x |
| reconf_done | output | 1 | One-cycle pulse after an accepted reshape |
| reconf_err | output | 1 | One-cycle pulse after a refused reshape |

## Verification
The mapping is swept over every in-range coordinate for each mesh shape, from the reset shape down to x = 0. Random junk is placed in the out-of-range coordinate bits. An exact address match against an independent model tells a wrong permutation from a wrong Gray encoding. The address tables from before and after each reshape are compared through the halve/double relation. This comparison separates a wrong rotation direction from a right one, because both kinds of error keep adjacency intact. A randomly seeded sequence mixes reshapes, idle cycles, resets and refused requests, which exposes state that leaks across commands.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE   = 2'd0,
        CMD_DONE   = 2'd1,
        CMD_REJECT = 2'd2
    } cmd_status_e;

    // reflected Gray code of a value
    function automatic logic [31:0] refl_gray(input logic [31:0] v);
        return v ^ (v >> 1);
    endfunction

    // mask of the n lowest bits
    function automatic logic [31:0] low_mask(input int n);
        if (n >= 32) return '1;
        if (n <= 0)  return '0;
        return (32'd1 << n) - 32'd1;
    endfunction

endpackage

// File: rtl/pgc_map_state.sv
module pgc_map_state
    import pgc_pkg::*;
#(
    parameter int ORDER  = 4,
    parameter int X_EXP0 = 2,
    parameter int SW     = 2,
    parameter int LW     = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reconf_req,
    output logic [LW-1:0]         x_exp,
    output logic [ORDER*SW-1:0]   sig_flat,
    output cmd_status_e           status
);

    logic [SW-1:0] sig_q [ORDER];
    logic [SW-1:0] sig_d [ORDER];

    // rotated permutation: X section shifts down, old entry 0 heads the Y section
    always_comb begin
        for (int k = 0; k < ORDER; k++) begin
            if (k + 1 < int'(x_exp))
                sig_d[k] = sig_q[(k + 1) % ORDER];
            else if (k + 1 == int'(x_exp))
                sig_d[k] = sig_q[0];
            else
                sig_d[k] = sig_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_exp  <= LW'(X_EXP0);
            status <= CMD_IDLE;
            for (int k = 0; k < ORDER; k++)
                sig_q[k] <= SW'((k + ORDER - X_EXP0) % ORDER);
        end else begin
            status <= CMD_IDLE;
            if (reconf_req) begin
                if (x_exp == '0) begin
                    status <= CMD_REJECT;
                end else begin
                    x_exp  <= x_exp - LW'(1);
                    status <= CMD_DONE;
                    for (int k = 0; k < ORDER; k++)
                        sig_q[k] <= sig_d[k];
                end
            end
        end
    end

    for (genvar g = 0; g < ORDER; g++) begin : g_flat
        assign sig_flat[g*SW +: SW] = sig_q[g];
    end

endmodule

// File: rtl/pgc_addr_scatter.sv
module pgc_addr_scatter
    import pgc_pkg::*;
#(
    parameter int ORDER = 4,
    parameter int SW    = 2,
    parameter int LW    = 3
) (
    input  logic [LW-1:0]       x_exp,
    input  logic [ORDER*SW-1:0] sig_flat,
    input  logic [ORDER-1:0]    ci,
    input  logic [ORDER-1:0]    cj,
    output logic [ORDER-1:0]    addr
);

    logic [ORDER-1:0] gi;
    logic [ORDER-1:0] gj;
    logic [ORDER-1:0] bitv;

    always_comb begin
        gi = ORDER'(refl_gray(32'(ci) & low_mask(int'(x_exp))));
        gj = ORDER'(refl_gray(32'(cj) & low_mask(ORDER - int'(x_exp))));
        addr = '0;
        for (int k = 0; k < ORDER; k++) begin
            if (k < int'(x_exp))
                bitv = ORDER'(gi[k]);
            else
                bitv = ORDER'((32'(gj) >> (k - int'(x_exp))) & 32'd1);
            addr = addr | (bitv << sig_flat[k*SW +: SW]);
        end
    end

endmodule

// File: rtl/pgc_pair_logic.sv
module pgc_pair_logic
    import pgc_pkg::*;
#(
    parameter int ORDER = 4,
    parameter int LW    = 3
) (
    input  logic [LW-1:0]    x_exp,
    input  logic [ORDER-1:0] ci,
    input  logic [ORDER-1:0] cj,
    output logic [ORDER-1:0] peer_i,
    output logic [ORDER-1:0] peer_j,
    output logic             send_high
);

    logic [ORDER-1:0] mi;
    logic [ORDER-1:0] mj;
    logic [ORDER-1:0] psum;

    always_comb begin
        mi   = ci & ORDER'(low_mask(int'(x_exp)));
        mj   = cj & ORDER'(low_mask(ORDER - int'(x_exp)));
        psum = mi + mj + (mj >> 1);
        send_high = psum[0];
        peer_i = mi;
        peer_j = (int'(x_exp) < ORDER) ? (mj ^ ORDER'(1)) : mj;
    end

endmodule

// File: rtl/pgc_mesh_mapper.sv
module pgc_mesh_mapper
    import pgc_pkg::*;
#(
    parameter int ORDER  = 4,
    parameter int X_EXP0 = ORDER / 2,
    localparam int SW    = (ORDER > 1) ? $clog2(ORDER) : 1,
    localparam int LW    = $clog2(ORDER + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reconf_req,
    input  logic [ORDER-1:0] q_i,
    input  logic [ORDER-1:0] q_j,
    output logic [ORDER-1:0] node_addr,
    output logic [ORDER-1:0] peer_addr,
    output logic             send_high,
    output logic [LW-1:0]    x_exp,
    output logic             reconf_done,
    output logic             reconf_err
);

    logic [ORDER*SW-1:0] sig_flat;
    cmd_status_e         status;
    logic [ORDER-1:0]    peer_i;
    logic [ORDER-1:0]    peer_j;

    pgc_map_state #(.ORDER(ORDER), .X_EXP0(X_EXP0), .SW(SW), .LW(LW)) u_state (
        .clk(clk), .rst(rst), .reconf_req(reconf_req),
        .x_exp(x_exp), .sig_flat(sig_flat), .status(status)
    );

    pgc_pair_logic #(.ORDER(ORDER), .LW(LW)) u_pair (
        .x_exp(x_exp), .ci(q_i), .cj(q_j),
        .peer_i(peer_i), .peer_j(peer_j), .send_high(send_high)
    );

    pgc_addr_scatter #(.ORDER(ORDER), .SW(SW), .LW(LW)) u_node (
        .x_exp(x_exp), .sig_flat(sig_flat), .ci(q_i), .cj(q_j), .addr(node_addr)
    );

    pgc_addr_scatter #(.ORDER(ORDER), .SW(SW), .LW(LW)) u_peer (
        .x_exp(x_exp), .sig_flat(sig_flat), .ci(peer_i), .cj(peer_j), .addr(peer_addr)
    );

    assign reconf_done = (status == CMD_DONE);
    assign reconf_err  = (status == CMD_REJECT);

endmodule

// File: rtl/pgc_mesh_mapper_chk.sv
module pgc_mesh_mapper_chk #(
    parameter int ORDER = 4,
    parameter int LW    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             reconf_req,
    input logic [ORDER-1:0] node_addr,
    input logic [ORDER-1:0] peer_addr,
    input logic [LW-1:0]    x_exp,
    input logic             reconf_done,
    input logic             reconf_err
);

    // R5: accepted request shrinks X by one and pulses done
    a_r5_accept_step: assert property (@(posedge clk) disable iff (rst)
        (reconf_req && x_exp != '0) |=> (reconf_done && x_exp == $past(x_exp) - LW'(1)));

    // R7: refused request pulses error and keeps the exponent
    a_r7_reject_hold: assert property (@(posedge clk) disable iff (rst)
        (reconf_req && x_exp == '0) |=> (reconf_err && !reconf_done && $stable(x_exp)));

    // R10: without a request nothing moves and no pulse appears
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !reconf_req |=> ($stable(x_exp) && !reconf_done && !reconf_err));

    // R8: partner address differs in one bit when Y has nodes
    a_r8_peer_one_bit: assert property (@(posedge clk) disable iff (rst)
        (int'(x_exp) < ORDER) |-> ($countones(node_addr ^ peer_addr) == 1));

    // R5/R7: the two pulses never coincide
    a_r5_pulse_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reconf_done, reconf_err}));

endmodule

bind pgc_mesh_mapper pgc_mesh_mapper_chk #(.ORDER(ORDER), .LW(LW)) u_chk (
    .clk(clk), .rst(rst), .reconf_req(reconf_req),
    .node_addr(node_addr), .peer_addr(peer_addr), .x_exp(x_exp),
    .reconf_done(reconf_done), .reconf_err(reconf_err)
);

// File: tb/pgc_mesh_mapper_test.sv
module pgc_mesh_mapper_test;

    localparam int PERIOD = 10;
    localparam int D      = 4;
    localparam int L0     = 2;
    localparam int LW     = $clog2(D + 1);
    localparam int NN     = 1 << D;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reconf_req = 1'b0;
    logic [D-1:0]  q_i = '0;
    logic [D-1:0]  q_j = '0;
    logic [D-1:0]  node_addr;
    logic [D-1:0]  peer_addr;
    logic          send_high;
    logic [LW-1:0] x_exp;
    logic          reconf_done;
    logic          reconf_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int ml;
    int msig [D];
    logic [D-1:0] tab  [NN][NN];
    logic [D-1:0] otab [NN][NN];

    always #(PERIOD/2) clk = ~clk;

    pgc_mesh_mapper #(.ORDER(D), .X_EXP0(L0)) uut (
        .clk(clk), .rst(rst), .reconf_req(reconf_req),
        .q_i(q_i), .q_j(q_j),
        .node_addr(node_addr), .peer_addr(peer_addr), .send_high(send_high),
        .x_exp(x_exp), .reconf_done(reconf_done), .reconf_err(reconf_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gcode(input int n);
        return n ^ (n >> 1);
    endfunction

    function automatic int mdl_addr(input int i, input int j);
        int a = 0;
        int gi = gcode(i & ((1 << ml) - 1));
        int gj = gcode(j & ((1 << (D - ml)) - 1));
        for (int k = 0; k < ml; k++)
            a |= ((gi >> k) & 1) << msig[k];
        for (int k = 0; k < D - ml; k++)
            a |= ((gj >> k) & 1) << msig[ml + k];
        return a;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        reconf_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        ml = L0;
        for (int k = 0; k < D; k++) msig[k] = (k + D - L0) % D;
        #1;
        chk(int'(x_exp) == L0, "R1 reset exponent", int'(x_exp), L0);
        chk(!reconf_done && !reconf_err, "R1 reset pulses low",
            int'({reconf_done, reconf_err}), 0);
    endtask

    task automatic sweep(input bit at_reset);
        int ni = 1 << ml;
        int nj = 1 << (D - ml);
        for (int i = 0; i < ni; i++) begin
            for (int j = 0; j < nj; j++) begin
                int pj;
                int par;
                @(negedge clk);
                q_i = D'(i | ($urandom << ml));
                q_j = D'(j | ($urandom << (D - ml)));
                #1;
                tab[i][j] = node_addr;
                chk(int'(node_addr) == mdl_addr(i, j), "R2/R3 node address",
                    int'(node_addr), mdl_addr(i, j));
                if (at_reset)
                    chk(int'(node_addr) == ((gcode(i) << (D - L0)) | gcode(j)),
                        "R1 row-major address", int'(node_addr),
                        (gcode(i) << (D - L0)) | gcode(j));
                pj = (nj > 1) ? (j ^ 1) : j;
                chk(int'(peer_addr) == mdl_addr(i, pj), "R8 peer address",
                    int'(peer_addr), mdl_addr(i, pj));
                par = (i + j + j / 2) & 1;
                chk(int'(send_high) == par, "R9 send_high", int'(send_high), par);
            end
        end
        for (int i = 0; i < ni; i++) begin
            for (int j = 0; j < nj; j++) begin
                if (ni > 1)
                    chk($countones(tab[i][j] ^ tab[(i + 1) % ni][j]) == 1,
                        "R4 X adjacency", int'(tab[(i + 1) % ni][j]), int'(tab[i][j]));
                if (nj > 1)
                    chk($countones(tab[i][j] ^ tab[i][(j + 1) % nj]) == 1,
                        "R4 Y adjacency", int'(tab[i][(j + 1) % nj]), int'(tab[i][j]));
                if (nj > 1)
                    chk(tab[i][j ^ 1] != tab[i][j], "R8 mutual pair distinct",
                        int'(tab[i][j ^ 1]), int'(tab[i][j]));
            end
        end
    endtask

    task automatic do_reconf();
        int old_l = ml;
        for (int i = 0; i < NN; i++)
            for (int j = 0; j < NN; j++)
                otab[i][j] = tab[i][j];
        @(negedge clk);
        reconf_req = 1'b1;
        @(negedge clk);
        reconf_req = 1'b0;
        #1;
        if (old_l == 0) begin
            chk(reconf_err && !reconf_done, "R7 reject pulse",
                int'({reconf_err, reconf_done}), 2);
            chk(int'(x_exp) == 0, "R7 exponent kept", int'(x_exp), 0);
        end else begin
            int t = msig[0];
            chk(reconf_done && !reconf_err, "R5 done pulse",
                int'({reconf_done, reconf_err}), 2);
            chk(int'(x_exp) == old_l - 1, "R5 exponent step", int'(x_exp), old_l - 1);
            for (int k = 0; k < old_l - 1; k++) msig[k] = msig[k + 1];
            msig[old_l - 1] = t;
            ml = old_l - 1;
        end
        @(negedge clk);
        #1;
        chk(!reconf_done && !reconf_err, "R5 single-cycle pulse",
            int'({reconf_done, reconf_err}), 0);
        sweep(1'b0);
        if (old_l == 0) begin
            for (int i = 0; i < (1 << ml); i++)
                for (int j = 0; j < (1 << (D - ml)); j++)
                    chk(tab[i][j] == otab[i][j], "R7 map unchanged",
                        int'(tab[i][j]), int'(otab[i][j]));
        end else begin
            for (int i = 0; i < (1 << ml); i++)
                for (int j = 0; j < (1 << (D - ml)); j++) begin
                    int si = 2 * i + ((i + j + j / 2) & 1);
                    chk(tab[i][j] == otab[si][j / 2], "R6 halve/double relation",
                        int'(tab[i][j]), int'(otab[si][j / 2]));
                end
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        sweep(1'b1);
        // directed walk down to x = 0, then a refused request
        for (int s = 0; s <= L0; s++) do_reconf();
        do_reconf();
        // R10: idle cycles leave the map alone
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            #1;
            chk(int'(x_exp) == ml, "R10 idle exponent", int'(x_exp), ml);
        end
        sweep(1'b0);
        // random mix of reshapes, idles and resets
        do_reset();
        sweep(1'b1);
        for (int it = 0; it < 25; it++) begin
            int r = $urandom % 5;
            if (r == 0) begin
                do_reset();
                sweep(1'b1);
            end else if (r <= 2) begin
                do_reconf();
            end else begin
                @(negedge clk);
                #1;
                chk(int'(x_exp) == ml, "R10 idle exponent", int'(x_exp), ml);
                sweep(1'b0);
            end
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule